// File: doc/BRIEF.md
# Peripheral write-protection controller

This block holds one write-protect bit for every peripheral on three peripheral bridge groups. Software never writes these bits directly. Instead it writes a single command word that names one peripheral and carries a key. The key clears protection, sets it, or sets it and locks it until the next reset. Three read-only status words show which peripherals are protected.

Every peripheral has an access-attempt input. An attempt on an unprotected peripheral is passed straight through on its grant output in the same cycle. An attempt on a protected peripheral is blocked and sets a sticky error flag for that peripheral. Flags are also set by a forbidden command on a locked peripheral. A separate 7-bit flag word records bridge-level errors that arrive on their own input. All flags are cleared by writing one. The interrupt output is level-based and follows the flags while the interrupt is enabled. The event output pulses once for each cycle in which a new error was recorded, while events are enabled.

The register port is a plain single-cycle write strobe with combinational read data, so it has no back-pressure. All other pins are plain level signals.

Top module: `pwp_ctrl`

## Requirements
- R1: After reset, group 1 status reads 0x00000002 and groups 0 and 2 read zero. All flags, both enables, `irq_o` and `evt_o` are zero.
- R2: A write to offset 0x00 is a command. Bits 15:0 are a peripheral number and bits 23:16 are a key. The number encodes group = number / 32 and bit = number % 32. Key 1 clears that peripheral's protect bit and key 2 sets it. Key 0 and every key above 3 change nothing. The status words for groups 0, 1 and 2 are at offsets 0x34, 0x38 and 0x3C, with the bit position equal to the peripheral index.
- R3: Groups 0, 1 and 2 have 12, 6 and 19 peripherals. A command whose number selects group 3 or higher, or a bit at or above the group's width, changes no protect bit and no flag.
- R4: Key 3 sets a peripheral's protect bit and locks it. Until reset, keys 1, 2 or 3 aimed at a locked peripheral leave its protection set and set that peripheral's error flag. Other peripherals remain changeable.
- R5: Writes to the status offsets have no effect. Unimplemented status bits read zero. Reads of the command offset and of unmapped offsets return zero.
- R6: A grant bit (`ok_a`/`ok_b`/`ok_c`) equals the attempt bit ANDed with NOT protected, in the same cycle. An attempt on a protected peripheral sets its error flag at the next clock edge.
- R7: The error flags of groups 0, 1 and 2 read at 0x14, 0x18 and 0x1C, at the peripheral's bit position. The bridge flags read at 0x10 in bits 6:0 and are set by `brg_err`. Writing one to a flag bit clears it and writing zero has no effect. A new error in the same cycle as a clear leaves the flag set.
- R8: Writing 1 to bit 0 of offset 0x09 sets the interrupt enable, and writing 1 to bit 0 of offset 0x08 clears it. Both offsets read the enable in bit 0. `irq_o` is the enable ANDed with the OR of all flags.
- R9: Bit 0 of offset 0x04 is the event enable and is readable. `evt_o` is high in the cycle after a cycle in which any new error was recorded (blocked access, locked-peripheral command or bridge error), but only if the enable was set in that earlier cycle. Otherwise `evt_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| acc_a | input | 12 | Write attempts, group 0 |
| acc_b | input | 6 | Write attempts, group 1 |
| acc_c | input | 19 | Write attempts, group 2 |
| brg_err | input | 7 | Bridge-level error strobes |
| ok_a | output | 12 | Granted attempts, group 0 |
| ok_b | output | 6 | Granted attempts, group 1 |
| ok_c | output | 19 | Granted attempts, group 2 |
| irq_o | output | 1 | Interrupt request |
| evt_o | output | 1 | Error event pulse |

## Verification
The assertions check four things on every cycle:
- a lock never drops and never sits on an unprotected peripheral;
- a blocked attempt is always captured in its flag;
- the event pulse only follows a recorded error while events were enabled;
- clearing the interrupt enable, or writing ones to bridge flags, takes effect on the next cycle.

Other behaviours are shown only by the bench scenarios, where the bench compares against its reference model on every clock:
- how peripheral numbers are decoded across the groups, including numbers past a group's width or in nonexistent groups;
- how each key value behaves;
- that status writes are ignored;
- the set-versus-clear race on a flag;
- that a lock is released by reset.

// File: rtl/pwp_pkg.sv
`timescale 1ns/1ps
package pwp_pkg;
  localparam int NGRP = 3;
  localparam int IDXW = 5;
  localparam int REGW = 32;

  localparam logic [7:0] OFF_CMD = 8'h00;
  localparam logic [7:0] OFF_EVC = 8'h04;
  localparam logic [7:0] OFF_IEC = 8'h08;
  localparam logic [7:0] OFF_IES = 8'h09;
  localparam logic [7:0] OFF_BRG = 8'h10;
  localparam logic [7:0] OFF_FLG = 8'h14;
  localparam logic [7:0] OFF_STS = 8'h34;

  typedef enum logic [1:0] {
    KEY_NOP = 2'd0,
    KEY_CLR = 2'd1,
    KEY_SET = 2'd2,
    KEY_LCK = 2'd3
  } key_e;
endpackage

// File: rtl/pwp_cmd_dec.sv
`timescale 1ns/1ps
module pwp_cmd_dec
  import pwp_pkg::*;
#(
  parameter int IDW  = 16,
  parameter int KEYW = 8
) (
  input  logic                 cmd_wr,
  input  logic [IDW+KEYW-1:0]  cmd_word,
  output logic [NGRP-1:0]      grp_hit,
  output logic [IDXW-1:0]      idx,
  output key_e                 key
);
  localparam int GRPW = IDW - IDXW;

  logic [IDW-1:0]  id;
  logic [KEYW-1:0] kraw;

  assign id   = cmd_word[IDW-1:0];
  assign kraw = cmd_word[IDW +: KEYW];
  assign idx  = id[IDXW-1:0];

  always_comb begin
    case (kraw)
      KEYW'(1): key = KEY_CLR;
      KEYW'(2): key = KEY_SET;
      KEYW'(3): key = KEY_LCK;
      default:  key = KEY_NOP;
    endcase
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_hit
    assign grp_hit[g] = cmd_wr && (id[IDW-1:IDXW] == GRPW'(g));
  end
endmodule

// File: rtl/pwp_group.sv
`timescale 1ns/1ps
module pwp_group
  import pwp_pkg::*;
#(
  parameter int           W        = 12,
  parameter logic [W-1:0] RST_PROT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_hit,
  input  logic [IDXW-1:0] cmd_idx,
  input  key_e            cmd_key,
  input  logic [W-1:0]    acc,
  input  logic            clr_wr,
  input  logic [W-1:0]    clr_mask,
  output logic [W-1:0]    prot,
  output logic [W-1:0]    err,
  output logic [W-1:0]    ok,
  output logic            new_err
);
  logic [W-1:0] prot_q, lock_q, err_q;
  logic [W-1:0] sel, upd, lock_viol, err_set, prot_d, lock_d, err_d;

  always_comb begin
    for (int i = 0; i < W; i++)
      sel[i] = cmd_hit && (cmd_key != KEY_NOP) && (cmd_idx == IDXW'(i));
  end

  assign lock_viol = sel & lock_q;
  assign upd       = sel & ~lock_q;

  always_comb begin
    prot_d = prot_q;
    lock_d = lock_q;
    case (cmd_key)
      KEY_CLR: prot_d = prot_q & ~upd;
      KEY_SET: prot_d = prot_q | upd;
      KEY_LCK: begin
        prot_d = prot_q | upd;
        lock_d = lock_q | upd;
      end
      default: ;
    endcase
  end

  assign err_set = (acc & prot_q) | lock_viol;
  assign err_d   = (clr_wr ? (err_q & ~clr_mask) : err_q) | err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= RST_PROT;
      lock_q <= '0;
      err_q  <= '0;
    end else begin
      prot_q <= prot_d;
      lock_q <= lock_d;
      err_q  <= err_d;
    end
  end

  assign prot    = prot_q;
  assign err     = err_q;
  assign ok      = acc & ~prot_q;
  assign new_err = |err_set;

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(lock_q) & ~lock_q) == '0) && ((lock_q & ~prot_q) == '0)));

  // R6
  err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc & prot_q) != '0) |=> (($past(acc & prot_q) & err_q) == $past(acc & prot_q)));
endmodule

// File: rtl/pwp_ctrl.sv
`timescale 1ns/1ps
module pwp_ctrl
  import pwp_pkg::*;
#(
  parameter int          GA_N  = 12,
  parameter int          GB_N  = 6,
  parameter int          GC_N  = 19,
  parameter int          BRG_N = 7,
  parameter logic [31:0] RST_A = 32'h0,
  parameter logic [31:0] RST_B = 32'h2,
  parameter logic [31:0] RST_C = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [REGW-1:0]   cfg_wdata,
  output logic [REGW-1:0]   cfg_rdata,
  input  logic [GA_N-1:0]   acc_a,
  input  logic [GB_N-1:0]   acc_b,
  input  logic [GC_N-1:0]   acc_c,
  input  logic [BRG_N-1:0]  brg_err,
  output logic [GA_N-1:0]   ok_a,
  output logic [GB_N-1:0]   ok_b,
  output logic [GC_N-1:0]   ok_c,
  output logic              irq_o,
  output logic              evt_o
);
  localparam int          IDW  = 16;
  localparam int          KEYW = 8;
  localparam int          GW [NGRP] = '{GA_N, GB_N, GC_N};
  localparam logic [31:0] GR [NGRP] = '{RST_A, RST_B, RST_C};

  logic [NGRP-1:0]            grp_hit, new_err_g;
  logic [IDXW-1:0]            cmd_idx;
  key_e                       cmd_key;
  logic [NGRP-1:0][REGW-1:0]  prot_p, err_p;
  logic                       ien_q, een_q, evt_q, any_err, new_any;
  logic [BRG_N-1:0]           brg_q;

  pwp_cmd_dec #(.IDW(IDW), .KEYW(KEYW)) u_dec (
    .cmd_wr   (cfg_wr && (cfg_addr == OFF_CMD)),
    .cmd_word (cfg_wdata[IDW+KEYW-1:0]),
    .grp_hit  (grp_hit),
    .idx      (cmd_idx),
    .key      (cmd_key)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int          W  = GW[g];
    localparam logic [31:0] R  = GR[g];
    localparam logic [7:0]  FO = OFF_FLG + 8'(4 * g);
    logic [W-1:0] acc_w, ok_w, prot_w, err_w;

    if (g == 0) begin : g_a
      assign acc_w = acc_a;
      assign ok_a  = ok_w;
    end else if (g == 1) begin : g_b
      assign acc_w = acc_b;
      assign ok_b  = ok_w;
    end else begin : g_c
      assign acc_w = acc_c;
      assign ok_c  = ok_w;
    end

    pwp_group #(.W(W), .RST_PROT(R[W-1:0])) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_hit  (grp_hit[g]),
      .cmd_idx  (cmd_idx),
      .cmd_key  (cmd_key),
      .acc      (acc_w),
      .clr_wr   (cfg_wr && (cfg_addr == FO)),
      .clr_mask (cfg_wdata[W-1:0]),
      .prot     (prot_w),
      .err      (err_w),
      .ok       (ok_w),
      .new_err  (new_err_g[g])
    );

    assign prot_p[g] = REGW'(prot_w);
    assign err_p[g]  = REGW'(err_w);
  end

  assign new_any = (|new_err_g) || (|brg_err);

  always_comb begin
    any_err = |brg_q;
    for (int g = 0; g < NGRP; g++) any_err = any_err | (|err_p[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      een_q <= 1'b0;
      evt_q <= 1'b0;
      brg_q <= '0;
    end else begin
      evt_q <= een_q && new_any;
      brg_q <= ((cfg_wr && cfg_addr == OFF_BRG) ? (brg_q & ~cfg_wdata[BRG_N-1:0]) : brg_q)
               | brg_err;
      if (cfg_wr && cfg_addr == OFF_EVC) een_q <= cfg_wdata[0];
      if (cfg_wr && cfg_addr == OFF_IES && cfg_wdata[0]) ien_q <= 1'b1;
      if (cfg_wr && cfg_addr == OFF_IEC && cfg_wdata[0]) ien_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == OFF_EVC) cfg_rdata[0] = een_q;
    if (cfg_addr == OFF_IEC || cfg_addr == OFF_IES) cfg_rdata[0] = ien_q;
    if (cfg_addr == OFF_BRG) cfg_rdata = REGW'(brg_q);
    for (int g = 0; g < NGRP; g++) begin
      if (cfg_addr == OFF_FLG + 8'(4 * g)) cfg_rdata = err_p[g];
      if (cfg_addr == OFF_STS + 8'(4 * g)) cfg_rdata = prot_p[g];
    end
  end

  assign irq_o = ien_q && any_err;
  assign evt_o = evt_q;

  // R9
  evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(een_q));

  // R9
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(new_any));

  // R8
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == OFF_IEC && cfg_wdata[0]) |=> !irq_o);

  // R7
  brg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == OFF_BRG && brg_err == '0)
      |=> ((brg_q & $past(cfg_wdata[BRG_N-1:0])) == '0));
endmodule

// File: tb/tb_pwp_ctrl.sv
`timescale 1ns/1ps
module tb_pwp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic [11:0] acc_a = '0;
  logic [5:0]  acc_b = '0;
  logic [18:0] acc_c = '0;
  logic [6:0]  brg_err = '0;
  logic [11:0] ok_a;
  logic [5:0]  ok_b;
  logic [18:0] ok_c;
  logic        irq_o, evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;

  always #10 clk = ~clk;

  pwp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_a(acc_a), .acc_b(acc_b),
    .acc_c(acc_c), .brg_err(brg_err), .ok_a(ok_a), .ok_b(ok_b), .ok_c(ok_c),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  // reference model
  int        wid [3] = '{12, 6, 19};
  bit [31:0] m_prot [3];
  bit [31:0] m_lock [3];
  bit [31:0] m_err [3];
  bit [31:0] m_brg;
  bit        m_ien, m_een, m_evt;

  function automatic bit [31:0] accv(int g);
    if (g == 0) return 32'(acc_a);
    if (g == 1) return 32'(acc_b);
    return 32'(acc_c);
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    if (a == 8'h04) return 32'(m_een);
    if (a == 8'h08 || a == 8'h09) return 32'(m_ien);
    if (a == 8'h10) return m_brg;
    for (int g = 0; g < 3; g++) begin
      if (a == 8'h14 + 8'(4 * g)) return m_err[g];
      if (a == 8'h34 + 8'(4 * g)) return m_prot[g];
    end
    return 32'h0;
  endfunction

  function automatic string req_of(bit [7:0] a);
    if (a == 8'h04) return "R9";
    if (a == 8'h08 || a == 8'h09) return "R8";
    if (a >= 8'h10 && a <= 8'h1C) return "R7";
    if (a >= 8'h34 && a <= 8'h3C) return "R2";
    return "R5";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prot = '{32'h0, 32'h2, 32'h0};
      m_lock = '{32'h0, 32'h0, 32'h0};
      m_err  = '{32'h0, 32'h0, 32'h0};
      m_brg = 0; m_ien = 0; m_een = 0; m_evt = 0;
    end else begin
      bit [31:0] se [3];
      bit ne;
      int id, key, g, b;
      for (int k = 0; k < 3; k++) se[k] = accv(k) & m_prot[k];
      if (cfg_wr && cfg_addr == 8'h00) begin
        id = int'(cfg_wdata[15:0]); key = int'(cfg_wdata[23:16]);
        g = id / 32; b = id % 32;
        if (g < 3 && b < wid[g] && key >= 1 && key <= 3) begin
          if (m_lock[g][b]) se[g][b] = 1'b1;
          else begin
            m_prot[g][b] = (key != 1);
            if (key == 3) m_lock[g][b] = 1'b1;
          end
        end
      end
      ne = (brg_err != 0);
      for (int k = 0; k < 3; k++) begin
        if (cfg_wr && cfg_addr == 8'h14 + 8'(4 * k)) m_err[k] &= ~cfg_wdata;
        m_err[k] |= se[k];
        if (se[k] != 0) ne = 1;
      end
      if (cfg_wr && cfg_addr == 8'h10) m_brg &= ~cfg_wdata;
      m_brg |= 32'(brg_err);
      m_evt = m_een && ne;
      if (cfg_wr && cfg_addr == 8'h04) m_een = cfg_wdata[0];
      if (cfg_wr && cfg_addr == 8'h09 && cfg_wdata[0]) m_ien = 1;
      if (cfg_wr && cfg_addr == 8'h08 && cfg_wdata[0]) m_ien = 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      bit anyf;
      anyf = (m_brg != 0) || (m_err[0] != 0) || (m_err[1] != 0) || (m_err[2] != 0);
      chk("R8", "irq_o", 32'(irq_o), 32'(m_ien && anyf));
      chk("R9", "evt_o", 32'(evt_o), 32'(m_evt));
      chk("R6", "ok_a", 32'(ok_a), 32'(acc_a) & ~m_prot[0]);
      chk("R6", "ok_b", 32'(ok_b), 32'(acc_b) & ~m_prot[1]);
      chk("R6", "ok_c", 32'(ok_c), 32'(acc_c) & ~m_prot[2]);
      chk(req_of(cfg_addr), "cfg_rdata", cfg_rdata, m_read(cfg_addr));
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk); #1;
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic cmd(input int id, input int key);
    wr(8'h00, (32'(key) << 16) | 32'(id));
  endtask

  task automatic rd_exp(input bit [7:0] a, input bit [31:0] e, input string req);
    @(negedge clk); #1;
    cfg_addr = a;
    #5 chk(req, $sformatf("read %h", a), cfg_rdata, e);
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    do_reset();
    live = 1;
    // R1 reset state
    rd_exp(8'h38, 32'h2, "R1");
    rd_exp(8'h34, 32'h0, "R1");
    rd_exp(8'h3C, 32'h0, "R1");
    rd_exp(8'h14, 32'h0, "R1");
    chk("R1", "irq_o", 32'(irq_o), 0);
    chk("R1", "evt_o", 32'(evt_o), 0);
    // R2 set and clear
    cmd(3, 2);   rd_exp(8'h34, 32'h8, "R2");
    cmd(82, 2);  rd_exp(8'h3C, 32'h40000, "R2");
    cmd(33, 1);  rd_exp(8'h38, 32'h0, "R2");
    cmd(5, 0);   cmd(5, 7); cmd(5, 8'hFF);
    rd_exp(8'h34, 32'h8, "R2");
    // R3 unimplemented numbers
    cmd(12, 2); cmd(38, 2); cmd(96, 2); cmd(16'hFFFF, 2);
    rd_exp(8'h34, 32'h8, "R3");
    rd_exp(8'h38, 32'h0, "R3");
    rd_exp(8'h3C, 32'h40000, "R3");
    rd_exp(8'h14, 32'h0, "R3");
    // R5 read-only status
    wr(8'h34, 32'hFFFFFFFF); wr(8'h38, 32'hFFFFFFFF);
    rd_exp(8'h34, 32'h8, "R5");
    rd_exp(8'h38, 32'h0, "R5");
    rd_exp(8'h00, 32'h0, "R5");
    // R6 blocked access
    @(negedge clk); #1 acc_a = 12'h00C;
    #5 chk("R6", "ok_a blocked", 32'(ok_a), 32'h4);
    @(negedge clk); #1 acc_a = '0;
    rd_exp(8'h14, 32'h8, "R6");
    // R8 interrupt enable
    chk("R8", "irq disabled", 32'(irq_o), 0);
    wr(8'h09, 1);
    #5 chk("R8", "irq enabled", 32'(irq_o), 1);
    rd_exp(8'h08, 32'h1, "R8");
    wr(8'h08, 1);
    rd_exp(8'h09, 32'h0, "R8");
    chk("R8", "irq cleared", 32'(irq_o), 0);
    // R7 flag clear
    wr(8'h14, 0); rd_exp(8'h14, 32'h8, "R7");
    wr(8'h14, 8); rd_exp(8'h14, 32'h0, "R7");
    @(negedge clk); #1;
    cfg_wr = 1; cfg_addr = 8'h14; cfg_wdata = 8; acc_a = 12'h008;
    @(negedge clk); #1;
    cfg_wr = 0; acc_a = '0;
    rd_exp(8'h14, 32'h8, "R7");
    wr(8'h14, 8);
    @(negedge clk); #1 brg_err = 7'h05;
    @(negedge clk); #1 brg_err = '0;
    rd_exp(8'h10, 32'h5, "R7");
    wr(8'h10, 1); rd_exp(8'h10, 32'h4, "R7");
    wr(8'h10, 4); rd_exp(8'h10, 32'h0, "R7");
    // R9 event
    @(negedge clk); #1 acc_c = 19'h40000;
    @(negedge clk); #1 acc_c = '0;
    #5 chk("R9", "evt while disabled", 32'(evt_o), 0);
    wr(8'h1C, 32'h40000);
    wr(8'h04, 1);
    rd_exp(8'h04, 32'h1, "R9");
    @(negedge clk); #1 acc_b = 6'h3F;
    @(negedge clk); #1 acc_b = '0;
    #5 chk("R9", "evt no error", 32'(evt_o), 0);
    @(negedge clk); #1 acc_c = 19'h40000;
    @(negedge clk); #1 acc_c = '0;
    #5 chk("R9", "evt pulse", 32'(evt_o), 1);
    @(negedge clk); #5 chk("R9", "evt one cycle", 32'(evt_o), 0);
    wr(8'h1C, 32'h40000);
    // R4 lock
    cmd(4, 3);  rd_exp(8'h34, 32'h18, "R4");
    rd_exp(8'h14, 32'h0, "R4");
    cmd(4, 1);  rd_exp(8'h34, 32'h18, "R4");
    rd_exp(8'h14, 32'h10, "R4");
    cmd(4, 2);  cmd(3, 1);
    rd_exp(8'h34, 32'h10, "R4");
    // R1 / R4 reset releases lock
    do_reset();
    rd_exp(8'h34, 32'h0, "R1");
    rd_exp(8'h38, 32'h2, "R1");
    cmd(4, 2); cmd(4, 1);
    rd_exp(8'h34, 32'h0, "R4");
    rd_exp(8'h14, 32'h0, "R4");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule